// File: doc/BRIEF.md
# Exception NaN Payload Encoder

This block forms a quiet NaN whose payload records why and where a fault happened. The low byte of the payload holds an 8-bit exception code. Above it sits the word address of the faulting instruction, relative to the code base, in bitwise-inverted form and cut to the width the chosen format has room for. The encoder serves the trap path of a floating-point unit: when an exception is to be signalled as a value, the unit hands over the current instruction pointer and the rest of the context, and takes back a result word it can write to the destination.

The instruction pointer already points past the faulting instruction. To get the fault address, the block first turns the byte offset from the code base into a word offset. It then subtracts the instruction length, which it decodes from a 3-bit length field. Half, single and double precision are supported. The result is always 64 bits, with zeros above the chosen format. The output register is loaded one cycle after a valid strobe and keeps its value until the next strobe.

Top module: `nan_payload_enc`

## Requirements
- R1: While rst_ni is low, and until the first strobe after reset, valid_o is 0 and result_o is 0.
- R2: valid_o is high in the cycle after valid_i was sampled high, and low in the cycle after it was sampled low.
- R3: The instruction length in 32-bit words is decoded from len_code_i as follows: codes 0, 1, 2 and 3 give 1, codes 4 and 5 give 2, code 6 gives 3, and code 7 gives 4.
- R4: The inverted address A is the bitwise NOT of (((ip_i - base_i) >> 2) - length), computed modulo 2^64.
- R5: When prec_i = 0 (half precision), result_o = 0x7E00 | (A[0] << 8) | exc_code_i[7:0], and bits 63:16 are zero.
- R6: When prec_i = 1 (single precision), result_o = 0x7FC00000 | (A[13:0] << 8) | exc_code_i[7:0], and bits 63:32 are zero.
- R7: When prec_i = 2 (double precision), result_o = 0x7FF8000000000000 | (A[42:0] << 8) | exc_code_i[7:0].
- R8: exc_code_i[15:8] has no effect on result_o.
- R9: When prec_i = 3 (reserved), result_o is all zeros.
- R10: When valid_i is low, result_o keeps its value, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Strobe that loads a new result |
| ip_i | input | 64 | Instruction pointer, already past the faulting instruction |
| base_i | input | 64 | Code base pointer |
| len_code_i | input | 3 | Instruction length field |
| exc_code_i | input | 16 | Exception code; only the low byte is used |
| prec_i | input | 2 | Precision: 0 half, 1 single, 2 double, 3 reserved |
| valid_o | output | 1 | Result valid, one cycle after the strobe |
| result_o | output | 64 | NaN result, zero-extended |

## Verification
The assertions assume that valid_i and prec_i are known at every sampled edge after reset, and that a strobe can come in any cycle, including back to back. The output properties compare against the inputs of the previous cycle. They depend only on the format bits and the code byte, so they hold for any pointer values, including bases above the pointer and offsets that are not word aligned. The stimulus drives inputs half a period away from the edge. It sweeps every length code and every precision against pointer pairs that cover these unusual cases, with random upper code bytes, and it changes the inputs while valid_i is low to show that the result holds.

// File: rtl/nan_enc_pkg.sv
package nan_enc_pkg;
  localparam int RES_W  = 64;
  localparam int BYTE_W = 8;
  localparam int N_FMT  = 3;

  typedef enum logic [1:0] {
    PREC_HALF   = 2'd0,
    PREC_SINGLE = 2'd1,
    PREC_DOUBLE = 2'd2,
    PREC_RSVD   = 2'd3
  } prec_e;

  // payload bits carried above the code byte, per format
  function automatic int pay_w(int fmt);
    case (fmt)
      0:       return 1;
      1:       return 14;
      default: return 43;
    endcase
  endfunction

  // quiet NaN pattern (sign 0, exponent all ones, quiet bit set)
  function automatic logic [RES_W-1:0] qnan_bits(int fmt);
    case (fmt)
      0:       return 64'h0000_0000_0000_7E00;
      1:       return 64'h0000_0000_7FC0_0000;
      default: return 64'h7FF8_0000_0000_0000;
    endcase
  endfunction
endpackage

// File: rtl/nan_len_lut.sv
module nan_len_lut (
  input  logic [2:0] len_code_i,
  output logic [2:0] words_o
);
  always_comb begin
    unique case (len_code_i)
      3'd4, 3'd5: words_o = 3'd2;
      3'd6:       words_o = 3'd3;
      3'd7:       words_o = 3'd4;
      default:    words_o = 3'd1;
    endcase
  end
endmodule

// File: rtl/nan_addr_calc.sv
module nan_addr_calc #(
  parameter int ADDR_W = 64
) (
  input  logic [ADDR_W-1:0] ip_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [2:0]        words_i,
  output logic [ADDR_W-1:0] inv_addr_o
);
  logic [ADDR_W-1:0] byte_off, word_off, fault_word;

  assign byte_off   = ip_i - base_i;
  assign word_off   = byte_off >> 2;
  assign fault_word = word_off - ADDR_W'(words_i);
  assign inv_addr_o = ~fault_word;
endmodule

// File: rtl/nan_pack.sv
module nan_pack #(
  parameter int ADDR_W = 64,
  parameter int CODE_W = 16
) (
  input  logic [ADDR_W-1:0]                inv_addr_i,
  input  logic [CODE_W-1:0]                code_i,
  input  nan_enc_pkg::prec_e               prec_i,
  output logic [nan_enc_pkg::RES_W-1:0]    result_o
);
  import nan_enc_pkg::*;

  localparam logic [RES_W-1:0] CODE_MASK = (RES_W'(1) << BYTE_W) - 1;

  logic [RES_W-1:0] addr_ext, code_ext;
  logic [RES_W-1:0] cand [N_FMT];

  assign addr_ext = RES_W'(inv_addr_i);
  assign code_ext = RES_W'(code_i) & CODE_MASK;

  for (genvar g = 0; g < N_FMT; g++) begin : g_fmt
    localparam int               PW    = pay_w(g);
    localparam logic [RES_W-1:0] PMASK = (RES_W'(1) << PW) - 1;
    assign cand[g] = qnan_bits(g) | ((addr_ext & PMASK) << BYTE_W) | code_ext;
  end

  always_comb begin
    unique case (prec_i)
      PREC_HALF:   result_o = cand[0];
      PREC_SINGLE: result_o = cand[1];
      PREC_DOUBLE: result_o = cand[2];
      default:     result_o = '0;
    endcase
  end
endmodule

// File: rtl/nan_payload_enc.sv
module nan_payload_enc #(
  parameter int ADDR_W = 64,
  parameter int CODE_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] ip_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [2:0]        len_code_i,
  input  logic [CODE_W-1:0] exc_code_i,
  input  logic [1:0]        prec_i,
  output logic              valid_o,
  output logic [63:0]       result_o
);
  import nan_enc_pkg::*;

  logic [2:0]        words;
  logic [ADDR_W-1:0] inv_addr;
  logic [RES_W-1:0]  packed_d;
  logic [RES_W-1:0]  result_q;
  logic              valid_q;

  nan_len_lut i_len (
    .len_code_i (len_code_i),
    .words_o    (words)
  );

  nan_addr_calc #(.ADDR_W(ADDR_W)) i_addr (
    .ip_i       (ip_i),
    .base_i     (base_i),
    .words_i    (words),
    .inv_addr_o (inv_addr)
  );

  nan_pack #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) i_pack (
    .inv_addr_i (inv_addr),
    .code_i     (exc_code_i),
    .prec_i     (prec_e'(prec_i)),
    .result_o   (packed_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= 1'b0;
      result_q <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) result_q <= packed_d;
    end
  end

  assign valid_o  = valid_q;
  assign result_o = result_q;
endmodule

// File: rtl/nan_payload_enc_chk.sv
module nan_payload_enc_chk #(
  parameter int ADDR_W = 64,
  parameter int CODE_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [ADDR_W-1:0] ip_i,
  input logic [ADDR_W-1:0] base_i,
  input logic [2:0]        len_code_i,
  input logic [CODE_W-1:0] exc_code_i,
  input logic [1:0]        prec_i,
  input logic              valid_o,
  input logic [63:0]       result_o
);
  p_strobe_on_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  p_strobe_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o));
  p_half_fmt_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && prec_i == 2'd0) |=>
      (result_o[63:16] == '0 && result_o[15:9] == 7'h3F));
  p_single_fmt_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && prec_i == 2'd1) |=>
      (result_o[63:32] == '0 && result_o[31:22] == 10'h1FF));
  p_double_fmt_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && prec_i == 2'd2) |=> (result_o[63:51] == 13'h0FFF));
  p_code_byte_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && prec_i != 2'd3) |=> (result_o[7:0] == $past(exc_code_i[7:0])));
  p_reserved_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && prec_i == 2'd3) |=> (result_o == '0));
  always_comb begin
    if (!rst_ni) a_reset_r1: assert (!valid_o && result_o == '0);
  end
endmodule

bind nan_payload_enc nan_payload_enc_chk #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .ip_i       (ip_i),
  .base_i     (base_i),
  .len_code_i (len_code_i),
  .exc_code_i (exc_code_i),
  .prec_i     (prec_i),
  .valid_o    (valid_o),
  .result_o   (result_o)
);

// File: tb/test_nan_payload_enc.sv
module test_nan_payload_enc;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [63:0] ip_i = '0;
  logic [63:0] base_i = '0;
  logic [2:0]  len_code_i = '0;
  logic [15:0] exc_code_i = '0;
  logic [1:0]  prec_i = '0;
  logic        valid_o;
  logic [63:0] result_o;

  int n_checks = 0;
  int n_errors = 0;

  always #10 clk_i = ~clk_i;

  nan_payload_enc i_nan_payload_enc (
    .clk_i, .rst_ni, .valid_i, .ip_i, .base_i, .len_code_i,
    .exc_code_i, .prec_i, .valid_o, .result_o
  );

  function automatic logic [63:0] expect_val(logic [63:0] ip, logic [63:0] base,
                                             logic [2:0] lc, logic [15:0] code,
                                             logic [1:0] prec);
    logic [63:0] len, a;
    // R3 length table
    if (lc < 3'd4) len = 1;
    else if (lc < 3'd6) len = 2;
    else if (lc == 3'd6) len = 3;
    else len = 4;
    a = ~(((ip - base) >> 2) - len);  // R4
    case (prec)
      2'd0: return {48'h0, 7'b0111111, a[0], code[7:0]};             // R5
      2'd1: return {32'h0, 10'b0111111111, a[13:0], code[7:0]};      // R6
      2'd2: return {13'b0111111111111, a[42:0], code[7:0]};          // R7
      default: return 64'h0;                                          // R9
    endcase
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(logic [63:0] ip, logic [63:0] base, logic [2:0] lc,
                       logic [15:0] code, logic [1:0] prec);
    logic [63:0] exp;
    exp = expect_val(ip, base, lc, code, prec);
    @(negedge clk_i);
    valid_i = 1'b1; ip_i = ip; base_i = base; len_code_i = lc;
    exc_code_i = code; prec_i = prec;
    @(negedge clk_i);
    check("R2 valid_o", 64'(valid_o), 64'd1);
    check($sformatf("R3/R4/R5-R9 lc=%0d prec=%0d", lc, prec), result_o, exp);
  endtask

  logic [63:0] ips   [4] = '{64'h0000_0000_0001_0040, 64'h0000_0000_0000_0000,
                             64'hFFFF_FFFF_FFFF_FFF0, 64'h1234_5678_9ABC_DEF3};
  logic [63:0] bases [4] = '{64'h0000_0000_0001_0000, 64'h0000_0000_0000_0000,
                             64'h0000_0000_0000_1000, 64'h0000_0100_0000_0004};

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin : stim
    logic [63:0] held;
    #5;
    check("R1 reset valid_o", 64'(valid_o), 64'd0);
    check("R1 reset result_o", result_o, 64'd0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 idle valid_o", 64'(valid_o), 64'd0);
    check("R1 idle result_o", result_o, 64'd0);

    for (int p = 0; p < 4; p++)
      for (int pr = 0; pr < 4; pr++)
        for (int lc = 0; lc < 8; lc++)
          apply(ips[p], bases[p], 3'(lc), {8'($urandom), 8'(lc * 37 + pr * 5 + p)}, 2'(pr));

    // R8: upper code byte must not change the result
    for (int pr = 0; pr < 3; pr++) begin
      apply(64'h8000, 64'h100, 3'd5, 16'h00A5, 2'(pr));
      held = result_o;
      apply(64'h8000, 64'h100, 3'd5, 16'hFFA5, 2'(pr));
      check("R8 upper code byte", result_o, held);
    end

    // R10: hold while valid_i low; R2: valid_o drops
    apply(64'h4000, 64'h0, 3'd7, 16'h003C, 2'd2);
    held = result_o;
    @(negedge clk_i);
    valid_i = 1'b0; ip_i = 64'hDEAD_BEEF; len_code_i = 3'd0;
    exc_code_i = 16'h1111; prec_i = 2'd0;
    @(negedge clk_i);
    check("R2 valid_o low", 64'(valid_o), 64'd0);
    check("R10 hold", result_o, held);
    prec_i = 2'd3;
    @(negedge clk_i);
    check("R10 hold reserved", result_o, held);

    // back-to-back strobes
    apply(64'h20, 64'h0, 3'd0, 16'h0001, 2'd1);
    apply(64'h20, 64'h0, 3'd7, 16'h0002, 2'd0);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule